// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. A free-running enable pulse, `os_tick`, marks sixteen sample points per bit period; the receive line is brought through a short synchronizer and is then watched on those pulses. A falling edge starts a candidate frame. The receiver keeps the frame only if the line is still low at the middle of the start bit. Each later bit is sampled once at its centre.

The character format is set by plain control inputs: five to eight data bits, and an optional parity bit with one of four rules. The format is captured when the start bit is confirmed, so changing the controls in the middle of a frame cannot corrupt the character already in flight. Each finished character leaves on a valid/ready stream with three flags: parity error, framing error and break. A break is a line held low through a whole character. After a break the receiver waits for the line to go high before it looks for a new start bit. A three-bit status vector shows a register view whether a character is waiting, whether a frame is in progress, and whether the receiver is waiting for the line to rise after a break.

Back-pressure rules: the output is a single holding stage. `rx_valid` stays high, and data and flags stay unchanged, until a cycle in which `rx_ready` is high. If a new character completes while the stage is full and `rx_ready` is low, the new character is discarded and the held one is kept. A character that completes in the same cycle as a handshake replaces the one being taken.

Top module: `serial_rx_core`

## Requirements
- R1: `wlen_sel` sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits are received least significant bit first into `rx_data[0]` upward, and bits above the word length read as zero.
- R2: A low sample on an `os_tick` pulse starts a candidate frame. If the line is high eight ticks later, at the centre of the start bit, the candidate is dropped and no character is produced.
- R3: With `par_en`=1, one parity bit follows the data. `par_sel` 2'b00 expects an odd number of ones over data and parity, 2'b01 expects an even number, 2'b10 expects the parity bit to be 1, and 2'b11 expects it to be 0. `rx_perr` is 1 exactly when the rule is violated. With `par_en`=0 there is no parity bit and `rx_perr` is 0.
- R4: `rx_ferr` is 1 when the first stop bit is sampled as 0.
- R5: If every sample from the start bit through the first stop bit is 0, the character is delivered with `rx_brk`=1, `rx_ferr`=1 and `rx_data`=0.
- R6: After a break the receiver does not start a new frame until the line has been sampled high, however long the line stays low.
- R7: Only one stop bit is sampled. A start bit that follows the first stop bit at once is received as a new character, so senders that use one or two stop bits are both accepted.
- R8: While `rx_valid`=1 and `rx_ready`=0, data and flags stay stable. `rx_valid` falls in the cycle after a handshake unless a new character arrives. A character that completes while the stage is full and not being taken is discarded.
- R9: `line_stat[0]` is 1 while a character waits on the stream, `line_stat[1]` is 1 while a frame is in progress, and `line_stat[2]` is 1 while the receiver waits for the line to rise after a break. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sample enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| wlen_sel | input | 2 | Data bit count code |
| par_en | input | 1 | Parity bit present and checked |
| par_sel | input | 2 | Parity rule code |
| rx_valid | output | 1 | Character available |
| rx_ready | input | 1 | Consumer accepts the character |
| rx_data | output | 8 | Received data, zero-extended |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break detected for this character |
| line_stat | output | 3 | {waiting for high, frame active, character waiting} |

## Verification
The bench drives a line where each bit lasts three clocks per tick times sixteen ticks. It covers every word length with patterns that would expose bit reversal or garbage in the upper bits. It checks all four parity rules with both good and bad parity bits; a design that swapped odd and even would flag correct characters. It drives a short low glitch that should be dropped at the start-bit centre; a receiver that commits on the first edge would produce a phantom character. It holds the line low well past a character to catch a receiver that reports repeated breaks. It sends two frames back to back with a single stop bit, which fails if the receiver insists on a second stop bit. It withholds `rx_ready` while a second character arrives, to catch a holding stage that is overwritten.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLDLOW
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_ODD = 2'b00, PAR_EVEN = 2'b01, PAR_ONE = 2'b10, PAR_ZERO = 2'b11
  } par_rule_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;

  // unused data bits are zero, so the full-width reduction is exact
  function automatic logic parity_bad(par_rule_t rule, logic [CHAR_W-1:0] d, logic pbit);
    logic ones_odd;
    ones_odd = ^{d, pbit};
    case (rule)
      PAR_ODD:  return !ones_odd;
      PAR_EVEN: return ones_odd;
      PAR_ONE:  return !pbit;
      default:  return pbit;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= din;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic [1:0] par_sel,
  output logic       push,
  output rx_char_t   ch,
  output logic       busy,
  output logic       hold_low
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;
  localparam int LST = OSR - 1;

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [2:0]        last_idx;
  logic [CHAR_W-1:0] sh;
  logic              all_zero;
  logic              pen_q;
  par_rule_t         rule_q;
  logic              pbit;

  wire at_mid = tick && (cnt == CW'(MID));
  wire at_end = tick && (cnt == CW'(LST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      last_idx <= '0;
      sh       <= '0;
      all_zero <= 1'b0;
      pen_q    <= 1'b0;
      rule_q   <= PAR_ODD;
      pbit     <= 1'b0;
      push     <= 1'b0;
      ch       <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        ST_IDLE: if (tick && !rxs) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (at_mid) begin
          cnt <= '0;
          if (rxs) state <= ST_IDLE;
          else begin
            state    <= ST_DATA;
            idx      <= '0;
            sh       <= '0;
            all_zero <= 1'b1;
            last_idx <= 3'd4 + {1'b0, wlen_sel};
            pen_q    <= par_en;
            rule_q   <= par_rule_t'(par_sel);
          end
        end else if (tick) cnt <= cnt + CW'(1);
        ST_DATA: if (at_end) begin
          cnt      <= '0;
          sh[idx]  <= rxs;
          all_zero <= all_zero & ~rxs;
          if (idx == last_idx) state <= pen_q ? ST_PAR : ST_STOP;
          else                 idx   <= idx + 3'd1;
        end else if (tick) cnt <= cnt + CW'(1);
        ST_PAR: if (at_end) begin
          cnt      <= '0;
          pbit     <= rxs;
          all_zero <= all_zero & ~rxs;
          state    <= ST_STOP;
        end else if (tick) cnt <= cnt + CW'(1);
        ST_STOP: if (at_end) begin
          cnt     <= '0;
          push    <= 1'b1;
          ch.data <= sh;
          ch.ferr <= !rxs;
          ch.brk  <= all_zero & !rxs;
          ch.perr <= pen_q & parity_bad(rule_q, sh, pbit);
          state   <= (all_zero && !rxs) ? ST_HOLDLOW : ST_IDLE;
        end else if (tick) cnt <= cnt + CW'(1);
        ST_HOLDLOW: if (rxs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_START) || (state == ST_DATA) ||
                    (state == ST_PAR)   || (state == ST_STOP);
  assign hold_low = (state == ST_HOLDLOW);

  AST_FRAME_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(rxs)); // R2
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((ch.data >> (4'(last_idx) + 4'd1)) == '0)); // R1
  AST_BREAK_IS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ch.brk) |-> (ch.ferr && ch.data == '0)); // R5
  AST_REARM_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state) == ST_HOLDLOW) |-> $past(rxs)); // R6
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t char_in,
  input  logic     out_ready,
  output logic     out_valid,
  output rx_char_t out_char
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_char  <= '0;
    end else if (push && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_char  <= char_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char))); // R8
  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !push) |=> !out_valid); // R8
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk,
  output logic [2:0]        line_stat
);
  logic     rxs, push, busy, hold_low;
  rx_char_t ch, held;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs));

  serial_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxs(rxs),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_sel(par_sel),
    .push(push), .ch(ch), .busy(busy), .hold_low(hold_low));

  serial_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .char_in(ch),
    .out_ready(rx_ready), .out_valid(rx_valid), .out_char(held));

  assign rx_data   = held.data;
  assign rx_perr   = held.perr;
  assign rx_ferr   = held.ferr;
  assign rx_brk    = held.brk;
  assign line_stat = {hold_low, busy, rx_valid};
endmodule

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int TDIV = 3;
  localparam int BIT  = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen_sel = 2'b11;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       rx_ready = 1'b0;
  logic       rx_valid, rx_perr, rx_ferr, rx_brk;
  logic [7:0] rx_data;
  logic [2:0] line_stat;
  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tcnt    <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    os_tick <= (tcnt == 0);
  end

  serial_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_sel(par_sel),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .line_stat(line_stat));

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_par(logic [1:0] rule, logic [7:0] d);
    case (rule)
      2'b00:   return ~^d;
      2'b01:   return ^d;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_frame(logic [7:0] d, int nb, bit pen, bit pbit, bit stopv);
    rxd = 1'b0; wait_clk(BIT);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clk(BIT); end
    if (pen) begin rxd = pbit; wait_clk(BIT); end
    rxd = stopv; wait_clk(BIT);
    rxd = 1'b1;
  endtask

  task automatic take_char(string req, logic [7:0] d, bit pe, bit fe, bit bk);
    int n = 0;
    while (!rx_valid && n < 4000) begin wait_clk(1); n++; end
    chk(req, "valid", rx_valid, 1);
    chk(req, "data", rx_data, d);
    chk(req, "perr", rx_perr, pe);
    chk(req, "ferr", rx_ferr, fe);
    chk(req, "brk", rx_brk, bk);
    rx_ready = 1'b1; wait_clk(1);
    rx_ready = 1'b0; wait_clk(1);
    chk("R8", "valid after take", rx_valid, 0);
  endtask

  task automatic test_reset;
    chk("R9", "reset valid", rx_valid, 0);
    chk("R9", "reset status", line_stat, 3'b000);
    chk("R9", "reset flags", {rx_perr, rx_ferr, rx_brk}, 0);
  endtask

  task automatic test_word_lengths;
    logic [7:0] pat [4] = '{8'h15, 8'h2A, 8'h4D, 8'hA5};
    par_en = 1'b0;
    for (int w = 0; w < 4; w++) begin
      wlen_sel = 2'(w);
      fork
        drive_frame(pat[w], 5 + w, 0, 0, 1);
        begin wait_clk(BIT * 3); chk("R9", "busy mid-frame", line_stat[1], 1); end
      join
      wait_clk(BIT);
      take_char("R1", pat[w], 0, 0, 0);
    end
    wlen_sel = 2'b00;
    drive_frame(8'hFF, 5, 0, 0, 1); wait_clk(BIT * 2);
    take_char("R1", 8'h1F, 0, 0, 0);
  endtask

  task automatic test_parity;
    logic [7:0] d = 8'h6B;
    wlen_sel = 2'b11; par_en = 1'b1;
    for (int r = 0; r < 4; r++) begin
      par_sel = 2'(r);
      drive_frame(d, 8, 1, exp_par(2'(r), d), 1); wait_clk(BIT);
      take_char("R3", d, 0, 0, 0);
      drive_frame(d, 8, 1, ~exp_par(2'(r), d), 1); wait_clk(BIT);
      take_char("R3", d, 1, 0, 0);
    end
    par_en = 1'b0;
  endtask

  task automatic test_framing;
    wlen_sel = 2'b11; par_en = 1'b0;
    drive_frame(8'h3C, 8, 0, 0, 0); wait_clk(BIT * 3);
    take_char("R4", 8'h3C, 0, 1, 0);
    chk("R4", "no spurious char", rx_valid, 0);
  endtask

  task automatic test_break;
    wlen_sel = 2'b11; par_en = 1'b0;
    rxd = 1'b0; wait_clk(BIT * 12);
    take_char("R5", 8'h00, 0, 1, 1);
    chk("R6", "waiting for high", line_stat[2], 1);
    wait_clk(BIT * 24);
    chk("R6", "no char while low", rx_valid, 0);
    chk("R6", "still waiting", line_stat, 3'b100);
    rxd = 1'b1; wait_clk(BIT);
    chk("R6", "wait cleared", line_stat, 3'b000);
    drive_frame(8'h81, 8, 0, 0, 1); wait_clk(BIT);
    take_char("R6", 8'h81, 0, 0, 0);
  endtask

  task automatic test_glitch;
    rxd = 1'b0; wait_clk(4 * TDIV);
    rxd = 1'b1; wait_clk(BIT * 14);
    chk("R2", "glitch gives no char", rx_valid, 0);
    chk("R2", "glitch idle", line_stat, 3'b000);
  endtask

  task automatic test_one_stop;
    wlen_sel = 2'b11; par_en = 1'b0;
    fork
      begin drive_frame(8'hC3, 8, 0, 0, 1); drive_frame(8'h5A, 8, 0, 0, 1); end
      begin take_char("R7", 8'hC3, 0, 0, 0); take_char("R7", 8'h5A, 0, 0, 0); end
    join
    wait_clk(BIT);
  endtask

  task automatic test_backpressure;
    wlen_sel = 2'b11; par_en = 1'b0;
    drive_frame(8'h11, 8, 0, 0, 1); wait_clk(BIT);
    drive_frame(8'h22, 8, 0, 0, 1); wait_clk(BIT);
    chk("R8", "held valid", rx_valid, 1);
    chk("R8", "held data kept", rx_data, 8'h11);
    take_char("R8", 8'h11, 0, 0, 0);
    wait_clk(BIT);
    chk("R8", "second char dropped", rx_valid, 0);
  endtask

  initial begin
    wait_clk(5);
    test_reset();
    rst_n = 1'b1;
    wait_clk(BIT);
    test_word_lengths();
    test_parity();
    test_framing();
    test_glitch();
    test_break();
    test_one_stop();
    test_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule